// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block sequences a 3-bit successive-approximation converter built on a charge-redistribution capacitor array. A 4-bit step counter runs freely and picks one of sixteen steps. Each step decodes into a 16-bit control word for the analog side. The word covers the acquire/convert select, the capacitor grounding, the bit decisions, the input or reference connection, a read strobe, a discharge select and an output latch enable. The block also keeps a position for each of the four capacitor switches: ground, upper reference or input. Over the conversion steps it collects the comparator decisions, most significant bit first, and presents the finished 3-bit code.

One pass of sixteen steps is one conversion. Steps 0–3 acquire the input. Steps 4–11 convert, and steps 12–15 latch the result and discharge the array. Each bit takes two steps. The first step connects that bit's capacitor to the upper reference as a trial. On the second step the comparator result either keeps the capacitor there or sends it back to ground. The capacitor array, the comparator and the references are outside the block. All pins are plain level or pulse signals. The block has no handshake, and the result register is simply overwritten on every pass.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets the step to 0, every switch to ground (code 0) and `code` to 0. `eoc` is low in the cycle after reset.
- R2: Outside reset, `step_idx` rises by one on each clock and wraps from 15 to 0, whatever value it starts from.
- R3: Bits of `ctrl_word`, from 15 down to 0, are: convert select, ground for capacitors 3..0, decision for capacitors 3..0, connect for capacitors 3..0, read strobe, discharge select and latch enable. Steps 0–15 give 007A, 0002, 0002, 0000, 8000, F800, 8040, 8404, 8020, 8204, 8010, 8104, 7803, 7802, 7802 and 7802 in hex. During conversion at most one connect bit is high.
- R4: Switch position codes are 0 for ground, 1 for upper reference and 2 for input. Capacitor k occupies `sw_state[2k+1:2k]`. A connect bit with the convert select low moves its capacitor to the input at the next edge. Capacitor positions only change through a ground, connect or decision bit.
- R5: A ground bit moves its capacitor to ground at the next edge. A connect bit with the convert select high moves its capacitor to the upper reference. Capacitor 3 carries weight 4, capacitor 2 weight 2, capacitor 1 weight 1, and capacitor 0 is the unweighted terminating capacitor.
- R6: On a step with a decision bit set, `cmp_keep` high leaves that capacitor at the reference. `cmp_keep` low returns it to ground at the closing edge. Bits 2, 1 and 0 are decided on steps 7, 9 and 11 through capacitors 3, 2 and 1.
- R7: `code` takes the three decisions, most significant first, at the edge that closes step 12. It holds that value until the next such edge. With an ideal comparator the result is the held input rounded down to a whole code. For example, a held input of 5.3 codes gives code 5.
- R8: `eoc` is high during step 12 only.
- R9: Throughout steps 13–15 every capacitor sits at ground.
- R10: The convert select (bit 15) is high in steps 4 through 11 and low in every other step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_keep | input | 1 | Comparator: high when the trial level does not exceed the held input |
| step_idx | output | 4 | Current schedule step |
| ctrl_word | output | 16 | Decoded control word for the analog side |
| sw_state | output | 8 | Four 2-bit switch positions, capacitor 0 in the low bits |
| code | output | 3 | Latched conversion result |
| eoc | output | 1 | End-of-conversion pulse, same step as the latch enable |

## Verification
A wrong switch position reaches the ports one clock later through `sw_state`. From that clock on it also changes the comparator answer the analog model returns, so a corrupted trial or decision shows up in `code` after step 12 of the same pass. A step counter that skips or stalls is seen in the very next cycle on both `step_idx` and `ctrl_word`. A fault in the decision capture is visible only at the latch. The bench therefore checks each latched code against the held input rounded down, with directed inputs at zero, at full scale and just below a code boundary.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int NBIT        = 3;
  localparam int NCAP        = NBIT + 1;
  localparam int STEP_W      = 4;
  localparam int CONV_START  = 4;
  localparam int GROUND_STEP = 5;
  localparam int FIRST_TRIAL = 6;
  localparam int LATCH_STEP  = FIRST_TRIAL + 2 * NBIT;
  localparam int CW_W        = 3 * NCAP + 4;
  localparam int CAP_IDX_W   = $clog2(NCAP);

  typedef enum logic [1:0] {
    SW_GND = 2'd0,
    SW_REF = 2'd1,
    SW_IN  = 2'd2
  } sw_pos_e;

  typedef struct packed {
    logic            conv_mode;
    logic [NCAP-1:0] gnd_sel;
    logic [NCAP-1:0] keep_sel;
    logic [NCAP-1:0] in_sel;
    logic            rd_strobe;
    logic            dump_sel;
    logic            latch_en;
  } ctrl_word_t;
endpackage

// File: rtl/sar_step_sched.sv
module sar_step_sched
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [STEP_W-1:0] step,
  output ctrl_word_t        word
);
  int                 off;
  logic [CAP_IDX_W-1:0] cap;

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= step + STEP_W'(1);
  end

  always_comb begin
    word = '0;
    off  = int'(step) - FIRST_TRIAL;
    cap  = '0;
    if (step == '0) begin
      word.in_sel   = '1;
      word.dump_sel = 1'b1;
    end
    if (step == STEP_W'(1) || step == STEP_W'(2)) word.dump_sel = 1'b1;
    if (int'(step) >= CONV_START && int'(step) < LATCH_STEP) word.conv_mode = 1'b1;
    if (int'(step) == GROUND_STEP) word.gnd_sel = '1;
    if (off >= 0 && off < 2 * NBIT) begin
      cap = CAP_IDX_W'(NBIT - off / 2);
      if (off % 2 == 0) begin
        word.in_sel[cap] = 1'b1;
      end else begin
        word.keep_sel[cap] = 1'b1;
        word.rd_strobe     = 1'b1;
      end
    end
    if (int'(step) >= LATCH_STEP) begin
      word.gnd_sel  = '1;
      word.dump_sel = 1'b1;
      word.latch_en = (int'(step) == LATCH_STEP);
    end
  end

  assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> step == $past(step) + STEP_W'(1));

  assert_single_trial_R3: assert property (@(posedge clk) disable iff (rst)
    word.conv_mode |-> $onehot0(word.in_sel));
endmodule

// File: rtl/sar_cap_switches.sv
module sar_cap_switches
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_word_t        word,
  input  logic              cmp_keep,
  output logic [2*NCAP-1:0] sw_state
);
  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    sw_pos_e pos;

    always_ff @(posedge clk) begin
      if (rst) begin
        pos <= SW_GND;
      end else if (word.gnd_sel[k]) begin
        pos <= SW_GND;
      end else if (word.in_sel[k]) begin
        pos <= word.conv_mode ? SW_REF : SW_IN;
      end else if (word.keep_sel[k] && word.rd_strobe && !cmp_keep) begin
        pos <= SW_GND;
      end
    end

    assign sw_state[2*k +: 2] = pos;

    assert_trial_to_ref_R5: assert property (@(posedge clk) disable iff (rst)
      (word.conv_mode && word.in_sel[k] && !word.gnd_sel[k]) |=> sw_state[2*k +: 2] == 2'd1);

    assert_reject_reverts_R6: assert property (@(posedge clk) disable iff (rst)
      (word.keep_sel[k] && word.rd_strobe && !cmp_keep && !word.in_sel[k] && !word.gnd_sel[k])
        |=> sw_state[2*k +: 2] == 2'd0);
  end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg
  import sar_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_strobe,
  input  logic            latch_en,
  input  logic            cmp_keep,
  output logic [NBIT-1:0] code
);
  logic [NBIT-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      code  <= '0;
    end else begin
      if (rd_strobe) shreg <= {shreg[NBIT-2:0], cmp_keep};
      if (latch_en)  code  <= shreg;
    end
  end

  assert_code_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(code));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_keep,
  output logic [STEP_W-1:0] step_idx,
  output logic [CW_W-1:0]   ctrl_word,
  output logic [2*NCAP-1:0] sw_state,
  output logic [NBIT-1:0]   code,
  output logic              eoc
);
  ctrl_word_t word;

  sar_step_sched u_sched (
    .clk  (clk),
    .rst  (rst),
    .step (step_idx),
    .word (word)
  );

  sar_cap_switches u_caps (
    .clk      (clk),
    .rst      (rst),
    .word     (word),
    .cmp_keep (cmp_keep),
    .sw_state (sw_state)
  );

  sar_result_reg u_result (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (word.rd_strobe),
    .latch_en  (word.latch_en),
    .cmp_keep  (cmp_keep),
    .code      (code)
  );

  assign ctrl_word = word;
  assign eoc       = word.latch_en;

  assert_discharged_R9: assert property (@(posedge clk) disable iff (rst)
    (step_idx == STEP_W'(LATCH_STEP + 1)) |-> sw_state == '0);
endmodule

// File: tb/sar_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sar_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_keep;
  logic [3:0] step_idx;
  logic [15:0] ctrl_word;
  logic [7:0] sw_state;
  logic [2:0] code;
  logic       eoc;

  int checks = 0;
  int errors = 0;
  int held   = 0;   // held input in eighths of a code
  int vin    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sar_seq_ctrl u_sar_seq_ctrl (
    .clk(clk), .rst(rst), .cmp_keep(cmp_keep), .step_idx(step_idx),
    .ctrl_word(ctrl_word), .sw_state(sw_state), .code(code), .eoc(eoc)
  );

  function automatic int dac_of(logic [7:0] s);
    int v = 0;
    if (s[7:6] == 2'd1) v += 4;
    if (s[5:4] == 2'd1) v += 2;
    if (s[3:2] == 2'd1) v += 1;
    return v;
  endfunction

  assign cmp_keep = (dac_of(sw_state) * 8 <= held);

  function automatic logic [15:0] exp_word(int s);
    case (s)
      0:          return 16'h007A;
      1, 2:       return 16'h0002;
      3:          return 16'h0000;
      4:          return 16'h8000;
      5:          return 16'hF800;
      6:          return 16'h8040;
      7:          return 16'h8404;
      8:          return 16'h8020;
      9:          return 16'h8204;
      10:         return 16'h8010;
      11:         return 16'h8104;
      12:         return 16'h7803;
      default:    return 16'h7802;
    endcase
  endfunction

  // behavioural reference model
  int   m_step = 0;
  int   m_sw[4];
  int   m_code = 0;
  int   m_held_conv = 0;
  bit   m_q[$];

  function automatic logic [7:0] m_sw_vec();
    logic [7:0] v;
    for (int k = 0; k < 4; k++) v[2*k +: 2] = 2'(m_sw[k]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0;
      for (int k = 0; k < 4; k++) m_sw[k] = 0;
      m_code = 0;
      m_q.delete();
    end else begin
      logic [15:0] w;
      bit c;
      bit any_in;
      w = exp_word(m_step);
      c = (dac_of(m_sw_vec()) * 8 <= held);
      any_in = 0;
      for (int k = 0; k < 4; k++) if (m_sw[k] == 2) any_in = 1;
      for (int k = 0; k < 4; k++) begin
        if (w[11 + k])                      m_sw[k] = 0;
        else if (w[3 + k])                  m_sw[k] = w[15] ? 1 : 2;
        else if (w[7 + k] && w[2] && !c)    m_sw[k] = 0;
      end
      if (w[2]) m_q.push_back(c);
      if (w[0]) begin
        if (m_q.size() >= 3) m_code = 4 * m_q[0] + 2 * m_q[1] + m_q[2];
        m_held_conv = held;
        m_q.delete();
      end
      m_step = (m_step + 1) % 16;
      if (any_in) held <= vin;
    end
  end

  task automatic check(string req, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d step=%0d", req, what, act, exp_v, m_step);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2", step_idx, m_step, "step");
      check((exp_word(m_step)[15] != ctrl_word[15]) ? "R10" : "R3",
            ctrl_word, exp_word(m_step), "ctrl_word");
      if (m_step <= 6)       check("R4", sw_state, m_sw_vec(), "sw_state");
      else if (m_step <= 12) check("R6", sw_state, m_sw_vec(), "sw_state");
      else                   check("R9", sw_state, 0, "sw_state");
      check("R8", eoc, (m_step == 12), "eoc");
      check("R7", code, m_code, "code");
      if (m_step == 7) check("R5", sw_state[7:6], 1, "msb trial");
      if (m_step == 13) check("R7", code, m_held_conv / 8, "quantised code");
    end
  end

  task automatic run_conv(int fixed_vin);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      vin = (fixed_vin >= 0) ? fixed_vin : $urandom_range(0, 63);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", step_idx, 0, "reset step");
    check("R1", sw_state, 0, "reset switches");
    check("R1", code, 0, "reset code");
    check("R1", eoc, 0, "reset eoc");
    rst = 1'b0;
    // directed: 5.3 codes, zero, full scale, exact boundary, just below 1
    run_conv(42); run_conv(42);
    run_conv(0);  run_conv(0);
    run_conv(63); run_conv(63);
    run_conv(56); run_conv(56);
    run_conv(7);  run_conv(7);
    for (int n = 0; n < 20; n++) run_conv(-1);
    // reset in the middle of a conversion
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", step_idx, 0, "mid reset step");
    check("R1", sw_state, 0, "mid reset switches");
    check("R1", code, 0, "mid reset code");
    rst = 1'b0;
    for (int n = 0; n < 20; n++) run_conv(-1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule